// File: doc/BRIEF.md
# Secure Task-Swap Controller

This block sits between a shared reconfigurable accelerator platform and the user design loaded on it, and it controls the hand-over when one tenant's task is to be replaced by another. It holds a small bank of context registers that the user design writes and reads while it runs. When the platform raises a swap request, or the user design raises its own release line because its work is complete, the controller starts a grace window of fixed length. Swap-grant is raised only at the end of that window.

Inside the window every context register is scrubbed to zero, one per cycle. The mode is chosen by an input sampled when the sequence starts. In discard mode the contents are simply destroyed. In save mode each word is first encrypted and streamed out on the context output bus before it is erased. The encryption here is a stand-in, an XOR with a build-time key that is rotated per word, and it is kept apart from any data-path key. Plaintext context never reaches the export bus. While a sequence is under way the read port returns zero.

Grant stays high while either request line is still high. Once both have dropped the controller returns to idle, with the bank empty and ready for the next task.

Top module: `task_swap_ctrl`

## Requirements
- R1: After synchronous reset, swap_grant and ctx_valid are low, ctx_out is zero and every context register reads back as zero.
- R2: While idle, a write enable stores ctx_wr_data at index ctx_wr_idx. ctx_rd_data is registered: it shows the word at ctx_rd_idx one clock edge after the index is presented.
- R3: A sequence starts on the first clock edge that samples swap_req or release_req high while idle. swap_grant goes high exactly GRACE_CYCLES edges later (default 16) and stays low before that. GRACE_CYCLES must be at least the number of context words plus 2.
- R4: In save mode, word i (i = 0 to NUM_CTX-1, in rising order) appears on ctx_out with ctx_valid high after edge i+1 of the sequence, counting the start edge as edge 0. The value is the stored word XOR CTX_KEY rotated left by i bits. ctx_valid is high at no other time.
- R5: In discard mode (save_mode low at the start edge), ctx_valid stays low and ctx_out stays zero for the whole sequence.
- R6: By the time swap_grant rises, every context register is zero, and it reads back as zero after the return to idle. Whenever ctx_valid is low, ctx_out is zero.
- R7: Raising release_req alone starts the same scrub, export and grant sequence as swap_req. A one-cycle release pulse is enough.
- R8: A swap_req that arrives during a sequence already under way joins that sequence and does not move the grant edge.
- R9: swap_grant holds while swap_req or release_req is high. It drops, and the block returns to idle, on the first edge that samples both low.
- R10: Writes are ignored while a sequence or grant is under way. During that time ctx_rd_data reads zero, from the edge after the start edge onward.
- R11: The mode is captured at the start edge; toggling save_mode during the sequence has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_req | input | 1 | Platform request to swap the task out |
| release_req | input | 1 | User design asks to be released early |
| save_mode | input | 1 | 1 = encrypt and export context, 0 = discard it |
| ctx_wr_en | input | 1 | Context register write enable |
| ctx_wr_idx | input | IDX_W | Context register write index |
| ctx_wr_data | input | CTX_W | Context register write data |
| ctx_rd_idx | input | IDX_W | Context register read index |
| ctx_rd_data | output | CTX_W | Registered read data (zero outside idle) |
| swap_grant | output | 1 | Task may be replaced |
| ctx_out | output | CTX_W | Encrypted exported context word |
| ctx_valid | output | 1 | ctx_out carries a word |

## Verification
All outputs are registered, so each result is due a whole number of clock edges after the edge that samples its cause. Read data is due one edge after the index is presented. Context word i is due i+1 edges after the start edge, and grant is due after exactly GRACE_CYCLES edges. The bench changes inputs on falling edges and, inside a sequence, checks ctx_valid, ctx_out and swap_grant on the falling edge after every rising edge. It compares them against values computed from a per-edge index count. Checking every cycle catches both a result that comes early and one that comes late.

// File: rtl/swap_pkg.sv
package swap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE        = 2'd0,
    ST_SCRUB_SAVE  = 2'd1,
    ST_WAIT_WINDOW = 2'd2,
    ST_GRANT       = 2'd3
  } swap_state_e;
endpackage

// File: rtl/swap_fsm.sv
module swap_fsm
  import swap_pkg::*;
#(
  parameter int GRACE_CYCLES = 16,
  parameter int NUM_CTX      = 4,
  parameter int IDX_W        = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap_req,
  input  logic             release_req,
  input  logic             save_mode,
  output swap_state_e      state,
  output logic             word_fire,
  output logic [IDX_W-1:0] word_idx,
  output logic             mode_save,
  output logic             swap_grant
);
  localparam int CNT_W = $clog2(GRACE_CYCLES + 1);

  logic [CNT_W-1:0] win_cnt;
  logic             any_req;

  assign any_req   = swap_req | release_req;
  assign word_fire = (state == ST_SCRUB_SAVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      win_cnt    <= '0;
      word_idx   <= '0;
      mode_save  <= 1'b0;
      swap_grant <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (any_req) begin
            state     <= ST_SCRUB_SAVE;
            win_cnt   <= CNT_W'(1);
            word_idx  <= '0;
            mode_save <= save_mode;
          end
        end
        ST_SCRUB_SAVE: begin
          win_cnt  <= win_cnt + 1'b1;
          word_idx <= word_idx + 1'b1;
          if (word_idx == IDX_W'(NUM_CTX - 1)) state <= ST_WAIT_WINDOW;
        end
        ST_WAIT_WINDOW: begin
          win_cnt <= win_cnt + 1'b1;
          if (win_cnt == CNT_W'(GRACE_CYCLES)) begin
            swap_grant <= 1'b1;
            state      <= ST_GRANT;
          end
        end
        default: begin
          if (!any_req) begin
            swap_grant <= 1'b0;
            win_cnt    <= '0;
            state      <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R9: grant never drops while a request line is still high
  p_grant_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (swap_grant && any_req) |=> swap_grant);

  // R3: grant is only reached from the end of the waiting window
  p_grant_after_window_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(swap_grant) |-> ($past(state) == ST_WAIT_WINDOW));

  // R11: captured mode stays fixed while a sequence runs
  p_mode_held_r11: assert property (@(posedge clk) disable iff (rst)
    ((state != ST_IDLE) && ($past(state) != ST_IDLE)) |-> $stable(mode_save));
endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile #(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 32,
  parameter int IDX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             access_ok,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CTX_W-1:0] wr_data,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [CTX_W-1:0] clr_word,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTX_W-1:0] rd_data,
  output logic             all_zero
);
  logic [CTX_W-1:0] regs [NUM_CTX];

  for (genvar gi = 0; gi < NUM_CTX; gi++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[gi] <= '0;
      end else if (clr_en && (clr_idx == IDX_W'(gi))) begin
        regs[gi] <= '0;
      end else if (access_ok && wr_en && (wr_idx == IDX_W'(gi))) begin
        regs[gi] <= wr_data;
      end
    end
  end

  assign clr_word = regs[clr_idx];

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= access_ok ? regs[rd_idx] : '0;
  end

  always_comb begin
    all_zero = 1'b1;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (regs[i] != '0) all_zero = 1'b0;
    end
  end
endmodule

// File: rtl/ctx_cipher.sv
module ctx_cipher #(
  parameter int              NUM_CTX = 4,
  parameter int              CTX_W   = 32,
  parameter logic [CTX_W-1:0] CTX_KEY = 32'hA5C3_1E97,
  parameter int              IDX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             save,
  input  logic [IDX_W-1:0] idx,
  input  logic [CTX_W-1:0] plain,
  output logic [CTX_W-1:0] ctx_out,
  output logic             ctx_valid
);
  logic [CTX_W-1:0] key_tab [NUM_CTX];

  for (genvar gk = 0; gk < NUM_CTX; gk++) begin : g_key
    if (gk == 0) begin : g_plain_key
      assign key_tab[gk] = CTX_KEY;
    end else begin : g_rot_key
      assign key_tab[gk] = (CTX_KEY << gk) | (CTX_KEY >> (CTX_W - gk));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_out   <= '0;
      ctx_valid <= 1'b0;
    end else if (fire && save) begin
      ctx_out   <= plain ^ key_tab[idx];
      ctx_valid <= 1'b1;
    end else begin
      ctx_out   <= '0;
      ctx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/task_swap_ctrl.sv
module task_swap_ctrl
  import swap_pkg::*;
#(
  parameter int               NUM_CTX      = 4,
  parameter int               CTX_W        = 32,
  parameter int               GRACE_CYCLES = 16,
  parameter logic [CTX_W-1:0] CTX_KEY      = 32'hA5C3_1E97,
  parameter int               IDX_W        = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap_req,
  input  logic             release_req,
  input  logic             save_mode,
  input  logic             ctx_wr_en,
  input  logic [IDX_W-1:0] ctx_wr_idx,
  input  logic [CTX_W-1:0] ctx_wr_data,
  input  logic [IDX_W-1:0] ctx_rd_idx,
  output logic [CTX_W-1:0] ctx_rd_data,
  output logic             swap_grant,
  output logic [CTX_W-1:0] ctx_out,
  output logic             ctx_valid
);
  swap_state_e      state;
  logic             word_fire;
  logic [IDX_W-1:0] word_idx;
  logic             mode_save;
  logic [CTX_W-1:0] clr_word;
  logic             all_zero;
  logic             is_idle;

  assign is_idle = (state == ST_IDLE);

  swap_fsm #(
    .GRACE_CYCLES(GRACE_CYCLES),
    .NUM_CTX     (NUM_CTX),
    .IDX_W       (IDX_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .swap_req   (swap_req),
    .release_req(release_req),
    .save_mode  (save_mode),
    .state      (state),
    .word_fire  (word_fire),
    .word_idx   (word_idx),
    .mode_save  (mode_save),
    .swap_grant (swap_grant)
  );

  ctx_regfile #(
    .NUM_CTX(NUM_CTX),
    .CTX_W  (CTX_W),
    .IDX_W  (IDX_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .access_ok(is_idle),
    .wr_en    (ctx_wr_en),
    .wr_idx   (ctx_wr_idx),
    .wr_data  (ctx_wr_data),
    .clr_en   (word_fire),
    .clr_idx  (word_idx),
    .clr_word (clr_word),
    .rd_idx   (ctx_rd_idx),
    .rd_data  (ctx_rd_data),
    .all_zero (all_zero)
  );

  ctx_cipher #(
    .NUM_CTX(NUM_CTX),
    .CTX_W  (CTX_W),
    .CTX_KEY(CTX_KEY),
    .IDX_W  (IDX_W)
  ) u_cipher (
    .clk      (clk),
    .rst      (rst),
    .fire     (word_fire),
    .save     (mode_save),
    .idx      (word_idx),
    .plain    (clr_word),
    .ctx_out  (ctx_out),
    .ctx_valid(ctx_valid)
  );

  // R4: export only happens inside the grace window
  p_export_in_window_r4: assert property (@(posedge clk) disable iff (rst)
    ctx_valid |-> !swap_grant);

  // R6: the bank is empty when the grant rises
  p_clean_at_grant_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(swap_grant) |-> all_zero);

  // R10: read port is blanked during a sequence
  p_rd_blank_r10: assert property (@(posedge clk) disable iff (rst)
    !is_idle |=> (ctx_rd_data == '0));
endmodule

// File: tb/task_swap_ctrl_test.sv
`timescale 1ns/1ps
module task_swap_ctrl_test;
  localparam int          NCTX = 4;
  localparam int          W    = 32;
  localparam int          G    = 16;
  localparam logic [31:0] KEY  = 32'hA5C3_1E97;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        swap_req = 1'b0, release_req = 1'b0, save_mode = 1'b0;
  logic        ctx_wr_en = 1'b0;
  logic [1:0]  ctx_wr_idx = '0, ctx_rd_idx = '0;
  logic [31:0] ctx_wr_data = '0;
  logic [31:0] ctx_rd_data, ctx_out;
  logic        swap_grant, ctx_valid;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  task_swap_ctrl #(.NUM_CTX(NCTX), .CTX_W(W), .GRACE_CYCLES(G), .CTX_KEY(KEY)) uut (
    .clk(clk), .rst(rst), .swap_req(swap_req), .release_req(release_req),
    .save_mode(save_mode), .ctx_wr_en(ctx_wr_en), .ctx_wr_idx(ctx_wr_idx),
    .ctx_wr_data(ctx_wr_data), .ctx_rd_idx(ctx_rd_idx), .ctx_rd_data(ctx_rd_data),
    .swap_grant(swap_grant), .ctx_out(ctx_out), .ctx_valid(ctx_valid)
  );

  function automatic logic [31:0] rotl(input logic [31:0] v, input int n);
    return (n == 0) ? v : ((v << n) | (v >> (32 - n)));
  endfunction

  function automatic logic [31:0] enc_word(input logic [31:0] d, input int i);
    return d ^ rotl(KEY, i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<100000", cycles);
        finish_run();
      end
    end
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    ctx_wr_en = 1'b1; ctx_wr_idx = 2'(idx); ctx_wr_data = d;
    @(posedge clk);
    @(negedge clk);
    ctx_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int idx, input logic [31:0] exp, input string req);
    @(negedge clk);
    ctx_rd_idx = 2'(idx);
    @(posedge clk);
    @(negedge clk);
    chk(req, ctx_rd_data, exp);
  endtask

  // One full swap sequence with per-edge checking
  task automatic run_seq(input logic save, input logic use_rel, input logic pulse,
                         input logic merge, input logic flip,
                         input logic [31:0] d0, input logic [31:0] d1,
                         input logic [31:0] d2, input logic [31:0] d3);
    logic [31:0] dv [4];
    logic        exp_v;
    logic [31:0] exp_o;
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    for (int i = 0; i < NCTX; i++) wr(i, dv[i]);
    for (int i = 0; i < NCTX; i++) rd_chk(i, dv[i], "R2 readback");
    @(negedge clk);
    save_mode = save;
    if (use_rel) release_req = 1'b1; else swap_req = 1'b1;
    @(posedge clk);  // start edge
    for (int j = 1; j <= G; j++) begin
      @(posedge clk);
      @(negedge clk);
      exp_v = save && (j >= 1) && (j <= NCTX);
      exp_o = exp_v ? enc_word(dv[j-1], j-1) : 32'h0;
      chk(save ? "R4 export valid" : "R5 discard valid", {31'b0, ctx_valid}, {31'b0, exp_v});
      chk(save ? "R4 export word" : "R6 out zero", ctx_out, exp_o);
      chk(use_rel ? "R7 release grant timing" : (merge ? "R8 merged grant timing" : "R3 grant timing"),
          {31'b0, swap_grant}, {31'b0, (j >= G)});
      if (j == 1) begin
        ctx_rd_idx = 2'd1;
        if (pulse) release_req = 1'b0;
      end
      if (j == 2) begin
        chk("R10 read blank", ctx_rd_data, 32'h0);
        ctx_wr_en = 1'b1; ctx_wr_idx = 2'd3; ctx_wr_data = 32'hFFFF_0000;
        if (flip) save_mode = ~save;
      end
      if (j == 3) ctx_wr_en = 1'b0;
      if (merge && j == 5) swap_req = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R9 grant hold", {31'b0, swap_grant}, {31'b0, !pulse || merge});
    swap_req = 1'b0; release_req = 1'b0; save_mode = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 grant drop", {31'b0, swap_grant}, 32'h0);
    for (int i = 0; i < NCTX; i++) rd_chk(i, 32'h0, "R6 scrubbed");
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 grant", {31'b0, swap_grant}, 32'h0);
    chk("R1 valid", {31'b0, ctx_valid}, 32'h0);
    chk("R1 out", ctx_out, 32'h0);
    for (int i = 0; i < NCTX; i++) rd_chk(i, 32'h0, "R1 regs zero");

    // directed: save mode via swap_req, with write and mode flip in window (R4 R10 R11)
    run_seq(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1111_2222, 32'h8000_0001, 32'hDEAD_BEEF, 32'h0F0F_F0F0);
    // directed: discard mode (R5)
    run_seq(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hCAFE_F00D, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0001);
    // directed: early release, one-cycle pulse (R7)
    run_seq(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'hAAAA_5555, 32'h0, 32'h7, 32'h8000_0000);
    // directed: release then swap_req merged in (R8)
    run_seq(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0123_4567, 32'h89AB_CDEF, 32'h1357_9BDF, 32'h2468_ACE0);

    // random runs
    for (int r = 0; r < 8; r++) begin
      logic [3:0] pick;
      pick = 4'($urandom);
      run_seq(pick[0], pick[1], pick[1] & pick[2], pick[1] & pick[3], pick[2],
              $urandom, $urandom, $urandom, $urandom);
    end
    finish_run();
  end
endmodule